// File: doc/BRIEF.md
# Packet Stream Source

This block is a stream master that produces test packets for stream consumers further down the chip. When it is idle and its `start` input is high at a clock edge, it samples a packet length and a payload pattern selector. From the next cycle it presents beats on a valid/ready stream interface. The interface has no addressing: data goes point to point to a single consumer. A beat moves only in a cycle where `mTvalid` and `mTready` are both high. With the consumer always ready, one beat moves on every clock. Under backpressure the current beat is held unchanged until it is accepted.

One beat counter does three jobs. It finds the final beat of the packet, which is flagged with `mTlast`. It is also the payload for the ascending pattern, and it is the source of the descending pattern. A 16-bit LFSR gives a pseudo-random payload. An all-ones word gives a constant payload. `busy` is high while a packet is in flight. `done` pulses for one cycle once the packet has fully left.

Top module: `pkt_stream_src`

## Requirements
- R1: During and straight after reset, `mTvalid`, `mTlast`, `busy` and `done` are all low.
- R2: When `start` is high at a clock edge while `busy` is low, the block samples `lenIn` and `patSel` at that edge. In the following cycle `busy` and `mTvalid` are both high, presenting beat 0.
- R3: A packet has `lenIn` beats, except that a length of 0 gives a single beat. `mTlast` is high only on the final beat, whose index is the sampled length minus one.
- R4: A beat is consumed only at an edge where `mTvalid` and `mTready` are both high. While `mTready` stays high, beats follow one another on consecutive cycles with no gap.
- R5: While `mTvalid` is high and `mTready` is low, `mTvalid` stays high and `mTdata` and `mTlast` do not change at the next edge.
- R6: With `patSel` = 0, beat i carries the value i, zero-extended.
- R7: With `patSel` = 1, beat i of an N-beat packet carries N-1-i, so the final beat carries 0.
- R8: With `patSel` = 2, every beat carries all ones.
- R9: With `patSel` = 3, beat 0 carries 16'hACE1, zero-extended. Each later beat carries the next state of a 16-bit LFSR, next = {s[14:0], s[15]^s[13]^s[12]^s[10]}.
- R10: While a packet is in flight, changes on `lenIn` and `patSel` and pulses on `start` have no effect. No further packet follows unless `start` is raised again while idle.
- R11: `done` is high for exactly one cycle, the cycle after the final beat is consumed. `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a packet when sampled high while idle |
| lenIn | input | LEN_W | Packet length in beats, sampled at start; 0 means 1 |
| patSel | input | 2 | Payload pattern selector, sampled at start |
| mTvalid | output | 1 | Stream beat valid |
| mTready | input | 1 | Consumer ready |
| mTdata | output | DATA_W | Stream beat payload |
| mTlast | output | 1 | Final beat of the packet |
| busy | output | 1 | A packet is in flight |
| done | output | 1 | One-cycle pulse after the final beat is consumed |

## Verification
The hardest case to reach from the ports is a length or pattern change, or a second `start`, arriving while a beat is stalled mid-packet. In that case the latched state must win over the live inputs. To get there, the stimulus pulses `start` and rewrites `lenIn` and `patSel` while `mTready` toggles or follows a pseudo-random sequence, so many beats sit stalled when the inputs change. A scoreboard built from the length and pattern sampled at start then shows any leak of the new values into the payload or the packet length. It also checks that no extra packet appears afterwards.

// File: rtl/pkt_src_pkg.sv
package pkt_src_pkg;
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  typedef enum logic [1:0] {
    PAT_UP   = 2'd0,
    PAT_DOWN = 2'd1,
    PAT_ONES = 2'd2,
    PAT_LFSR = 2'd3
  } patSel_e;

  typedef struct packed {
    logic load;  // packet accepted: latch pattern, seed LFSR
    logic step;  // non-final beat consumed: advance LFSR
  } srcStrobe_t;
endpackage

// File: rtl/pkt_src_ctrl.sv
module pkt_src_ctrl
  import pkt_src_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] lenIn,
  input  logic             ready,
  output logic             valid,
  output logic             last,
  output logic             busy,
  output logic             done,
  output logic [LEN_W-1:0] beatCnt,
  output logic [LEN_W-1:0] lastIdx,
  output srcStrobe_t       strobe
);
  logic busyQ, doneQ, fire;
  logic [LEN_W-1:0] cntQ, lastQ;

  assign valid   = busyQ;
  assign busy    = busyQ;
  assign done    = doneQ;
  assign last    = busyQ && (cntQ == lastQ);
  assign fire    = busyQ && ready;
  assign beatCnt = cntQ;
  assign lastIdx = lastQ;

  always_comb begin
    strobe.load = !busyQ && start;
    strobe.step = fire && !last;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      cntQ  <= '0;
      lastQ <= '0;
    end else begin
      doneQ <= 1'b0;
      if (strobe.load) begin
        busyQ <= 1'b1;
        cntQ  <= '0;
        lastQ <= (lenIn == '0) ? '0 : lenIn - 1'b1;
      end else if (fire) begin
        if (last) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end else begin
          cntQ <= cntQ + 1'b1;
        end
      end
    end
  end

  p_last_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    last |-> valid);
  p_no_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (valid && ready && !last) |=> valid);
  p_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (busy && valid));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    (valid && ready && last) |=> (done && !busy));
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/pkt_src_dpath.sv
module pkt_src_dpath
  import pkt_src_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  srcStrobe_t        strobe,
  input  logic [1:0]        patSel,
  input  logic [LEN_W-1:0]  beatCnt,
  input  logic [LEN_W-1:0]  lastIdx,
  output logic [DATA_W-1:0] data
);
  localparam int CNT_PAD  = DATA_W - LEN_W;
  localparam int LFSR_PAD = DATA_W - LFSR_W;

  patSel_e patQ;
  logic [LFSR_W-1:0] lfsrQ;
  logic [LEN_W-1:0]  downCnt;

  assign downCnt = lastIdx - beatCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      patQ  <= PAT_UP;
      lfsrQ <= LFSR_SEED;
    end else if (strobe.load) begin
      patQ  <= patSel_e'(patSel);
      lfsrQ <= LFSR_SEED;
    end else if (strobe.step) begin
      lfsrQ <= {lfsrQ[LFSR_W-2:0], lfsrQ[15] ^ lfsrQ[13] ^ lfsrQ[12] ^ lfsrQ[10]};
    end
  end

  always_comb begin
    unique case (patQ)
      PAT_UP:   data = {{CNT_PAD{1'b0}}, beatCnt};
      PAT_DOWN: data = {{CNT_PAD{1'b0}}, downCnt};
      PAT_ONES: data = '1;
      default:  data = {{LFSR_PAD{1'b0}}, lfsrQ};
    endcase
  end
endmodule

// File: rtl/pkt_stream_src.sv
module pkt_stream_src
  import pkt_src_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  lenIn,
  input  logic [1:0]        patSel,
  output logic              mTvalid,
  input  logic              mTready,
  output logic [DATA_W-1:0] mTdata,
  output logic              mTlast,
  output logic              busy,
  output logic              done
);
  srcStrobe_t strobe;
  logic [LEN_W-1:0] beatCnt, lastIdx;

  pkt_src_ctrl #(.LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .lenIn(lenIn), .ready(mTready),
    .valid(mTvalid), .last(mTlast), .busy(busy), .done(done),
    .beatCnt(beatCnt), .lastIdx(lastIdx), .strobe(strobe)
  );

  pkt_src_dpath #(.DATA_W(DATA_W), .LEN_W(LEN_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .patSel(patSel),
    .beatCnt(beatCnt), .lastIdx(lastIdx), .data(mTdata)
  );

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mTvalid && !mTready) |=> (mTvalid && $stable(mTdata) && $stable(mTlast)));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mTvalid && !mTlast));
endmodule

// File: tb/pkt_stream_src_test.sv
module pkt_stream_src_test;
  localparam int DW = 32;
  localparam int LW = 12;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, mTready = 1'b0;
  logic [LW-1:0] lenIn = '0;
  logic [1:0] patSel = '0;
  logic mTvalid, mTlast, busy, done;
  logic [DW-1:0] mTdata;

  pkt_stream_src #(.DATA_W(DW), .LEN_W(LW)) uut (
    .clk(clk), .rstN(rstN), .start(start), .lenIn(lenIn), .patSel(patSel),
    .mTvalid(mTvalid), .mTready(mTready), .mTdata(mTdata), .mTlast(mTlast),
    .busy(busy), .done(done)
  );

  always #5 clk = ~clk;

  typedef struct { logic [DW-1:0] d; logic l; string tag; } beat_t;
  beat_t expQ[$];
  int checks = 0, fails = 0, readyMode = 0;
  bit ended = 0, monOn = 0;
  logic [15:0] rdyLfsr = 16'h1;

  function automatic logic [15:0] lfsrNext(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendPkt(int len, int pat, bit poke);
    int n;
    logic [15:0] s;
    beat_t b;
    n = (len == 0) ? 1 : len;
    s = 16'hACE1;
    @(negedge clk);
    while (busy || expQ.size() != 0) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      case (pat)
        0: begin b.d = DW'(i);         b.tag = "R6"; end
        1: begin b.d = DW'(n - 1 - i); b.tag = "R7"; end
        2: begin b.d = '1;             b.tag = "R8"; end
        default: begin b.d = DW'(s); s = lfsrNext(s); b.tag = "R9"; end
      endcase
      b.l = (i == n - 1);
      expQ.push_back(b);
    end
    lenIn = LW'(len); patSel = 2'(pat); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(mTvalid === 1'b1 && busy === 1'b1, "R2 valid/busy after start", {mTvalid, busy}, 2'b11);
    if (poke) begin
      lenIn = ~LW'(len); patSel = 2'(pat + 1);
      @(negedge clk);
      start = 1'b1;          // R10: must be ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  // Monitor / scoreboard
  initial begin
    bit prevStall = 0, prevFireMid = 0, doneDue = 0;
    logic [DW-1:0] sD;
    logic sL;
    beat_t b;
    wait (monOn);
    forever begin
      @(negedge clk);
      if (doneDue) chk(done === 1'b1 && busy === 1'b0, "R11 done after last", {done, busy}, 2'b10);
      else if (done !== 1'b0) chk(0, "R11 unexpected done", done, 0);
      doneDue = 0;
      if (prevStall)
        chk(mTvalid === 1'b1 && mTdata === sD && mTlast === sL, "R5 hold under stall", mTdata, sD);
      if (prevFireMid && readyMode == 0)
        chk(mTvalid === 1'b1, "R4 no gap", mTvalid, 1);
      prevFireMid = 0;
      case (readyMode)
        0: mTready = 1'b1;
        1: mTready = ~mTready;
        default: begin rdyLfsr = lfsrNext(rdyLfsr); mTready = rdyLfsr[0]; end
      endcase
      prevStall = (mTvalid === 1'b1) && !mTready;
      sD = mTdata; sL = mTlast;
      if (mTvalid === 1'b1 && mTready) begin
        if (expQ.size() == 0) chk(0, "R3 extra beat", mTdata, 0);
        else begin
          b = expQ.pop_front();
          chk(mTdata === b.d, b.tag, mTdata, b.d);
          chk(mTlast === b.l, "R3 last flag", mTlast, b.l);
          if (b.l) doneDue = 1; else prevFireMid = 1;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mTvalid === 0 && mTlast === 0 && busy === 0 && done === 0, "R1 reset state",
        {mTvalid, mTlast, busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(mTvalid === 0 && busy === 0, "R1 after reset", {mTvalid, busy}, 0);
    monOn = 1;
    readyMode = 0;
    sendPkt(5, 0, 0);
    sendPkt(4, 1, 0);
    sendPkt(0, 2, 0);   // R3 zero length -> one beat
    sendPkt(1, 3, 0);
    readyMode = 1;
    sendPkt(6, 3, 0);
    sendPkt(7, 1, 1);   // R10 changes mid-packet
    readyMode = 2;
    sendPkt(9, 0, 0);
    sendPkt(20, 3, 1);
    sendPkt(3, 2, 0);
    sendPkt(12, 0, 1);
    @(negedge clk);
    while (busy || expQ.size() != 0) @(negedge clk);
    repeat (4) begin
      @(negedge clk);
      chk(mTvalid === 1'b0 && busy === 1'b0, "R10 no stray packet", {mTvalid, busy}, 0);
    end
    chk(expQ.size() == 0, "R3 all beats seen", expQ.size(), 0);
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule